// File: doc/BRIEF.md
# XNOR-Feedback PRBS Generator

This block is a clocked linear-feedback shift register that produces pseudorandom binary sequences for exercising serial or parallel links. A parameter selects between a 7-stage register (period 127) and a 31-stage register (period 2^31 − 1). Every enabled clock shifts the state word one place toward the MSB, and the new LSB is the XNOR of two tap stages. Because the feedback is XNOR, the all-zero word is a legal member of the sequence and serves as the reset value. The all-ones word is the only state outside the sequence.

Downstream logic can take either the full parallel state word or a single serial bit, which is the MSB of the register. A seed strobe loads an arbitrary start word. A lock-up flag reports when the register holds all ones. When the recovery parameter is set, the block also leaves that state on the next enabled clock by returning to all zeros.

Top module: `prbs_gen`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the state becomes all zeros on that edge.
- R2: With `adv_i` high and `load_i` low, each rising edge takes state S to {S[W-2:0], fb}, where fb = NOT(S[TA-1] XOR S[TB-1]). In the 7-bit mode TA=7 and TB=6, so the words after reset run 00, 01, 03, 07, 0F, 1F, 3F, 7E, 7D, 7B, 77, 6F, 5F, 3E, 7C, 79 (hex).
- R3: With both `adv_i` and `load_i` low, the state does not change.
- R4: With `load_i` high, the next state is `seed_i`, whatever the value of `adv_i`.
- R5: After the seed 3F is loaded in the 7-bit mode, the following advances give 7E, 7D, 7B, 77, 6F, 5F, 3E.
- R6: In the 7-bit mode, 127 advances from all zeros visit 127 distinct words and return to all zeros.
- R7: With RECOVER = 0, an all-ones state stays all ones on every advance.
- R8: `lockup_o` is 1 exactly when every state bit is 1.
- R9: With RECOVER = 1, an advance from all ones (with `load_i` low) gives all zeros.
- R10: `serial_o` always equals the state MSB, bit W-1.
- R11: In the 31-bit mode the taps are TA=31 and TB=28, and the register follows the R2 rule with those taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance the sequence by one step |
| load_i | input | 1 | Replace the state with `seed_i`; takes priority over `adv_i` |
| seed_i | input | W | Seed word (W = 7 or 31, set by MODE) |
| state_o | output | W | Parallel state word |
| serial_o | output | 1 | Serial sequence bit (state MSB) |
| lockup_o | output | 1 | High while the state is all ones |

## Verification
Assertions check the following on every cycle:
- the reset result;
- that a seed load wins over an advance;
- that the state holds while idle;
- the one-place left shift;
- the lock-up rule selected by RECOVER, either staying stuck or returning to zero;
- that the flag implies a set MSB.

The exact feedback values can only be confirmed by the bench's scenarios. The same holds for the documented 16-word run, the seeded run from 3F, the full 127-step period with no repeated word, and the 31-bit taps. Those scenarios compare against an independent model and against known word lists.

// File: rtl/prbs_pkg.sv
// Package: shared mode type and tap selection for the PRBS generator.
// Assumes: only the two listed modes exist; every helper is a pure function.
package prbs_pkg;

    typedef enum logic [0:0] {
        PRBS7  = 1'b0,
        PRBS31 = 1'b1
    } prbs_mode_e;

    // Register length for a mode.
    function automatic int unsigned width_of(prbs_mode_e mode);
        return (mode == PRBS31) ? 31 : 7;
    endfunction

    // First feedback tap (1-based stage number): always the last stage.
    function automatic int unsigned tap_a_of(prbs_mode_e mode);
        return width_of(mode);
    endfunction

    // Second feedback tap (1-based stage number).
    function automatic int unsigned tap_b_of(prbs_mode_e mode);
        return (mode == PRBS31) ? 28 : 6;
    endfunction

endpackage

// File: rtl/prbs_shifter.sv
// Module: next-state logic. It shifts the word toward the MSB and inserts the
// XNOR of two tap stages at the LSB.
// Assumes: 1 <= TAP_B < TAP_A <= W; taps are 1-based stage numbers.
module prbs_shifter #(
    parameter int unsigned W     = 7,
    parameter int unsigned TAP_A = 7,
    parameter int unsigned TAP_B = 6
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);

    logic fb;

    // Feedback bit: XNOR of the two tap stages.
    always_comb fb = ~(cur_i[TAP_A-1] ^ cur_i[TAP_B-1]);

    // Shift one place toward the MSB and append the feedback bit.
    always_comb nxt_o = {cur_i[W-2:0], fb};

endmodule

// File: rtl/prbs_lock_detect.sv
// Module: flags the single stuck word (all ones) of an XNOR-feedback register.
// Assumes: combinational use; the flag follows the state within the same cycle.
module prbs_lock_detect #(
    parameter int unsigned W = 7
) (
    input  logic [W-1:0] cur_i,
    output logic         stuck_o
);

    // Stuck exactly when every stage holds a one.
    always_comb stuck_o = &cur_i;

endmodule

// File: rtl/prbs_state_reg.sv
// Module: the state register. It covers reset to zero, seed load (highest
// priority after reset), advance, and an optional escape from the stuck word.
// Assumes: synchronous active-low reset; nxt_i and stuck_i are derived from
// the current state.
module prbs_state_reg #(
    parameter int unsigned W       = 7,
    parameter bit          RECOVER = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic [W-1:0] nxt_i,
    input  logic         stuck_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] adv_val;

    // Advance target: the shifted word, or zero when escaping lock-up.
    generate
        if (RECOVER) begin : g_recover
            always_comb adv_val = stuck_i ? '0 : nxt_i;
        end else begin : g_plain
            always_comb adv_val = nxt_i;
        end
    endgenerate

    // State update: reset, then load, then advance, else hold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     state_q <= '0;
        else if (load_i) state_q <= seed_i;
        else if (adv_i)  state_q <= adv_val;
    end

    assign state_o = state_q;

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        !rst_ni |=> state_q == '0); // R1
    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> state_q == $past(seed_i)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !adv_i) |=> $stable(state_q)); // R3
    AST_SHIFT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !load_i && !(RECOVER && stuck_i))
            |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R2

    generate
        if (RECOVER) begin : g_ast_rec
            AST_ESCAPE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (adv_i && !load_i && stuck_i) |=> state_q == '0); // R9
        end else begin : g_ast_stuck
            AST_STAY_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (stuck_i && !load_i) |=> stuck_i); // R7
        end
    endgenerate

endmodule

// File: rtl/prbs_gen.sv
// Module: top of the XNOR-feedback PRBS generator. MODE picks the 7- or
// 31-stage register. RECOVER enables a return to zero from the stuck word.
// Assumes: single clock domain; inputs are synchronous to clk_i.
module prbs_gen #(
    parameter prbs_pkg::prbs_mode_e MODE    = prbs_pkg::PRBS7,
    parameter bit                   RECOVER = 1'b0,
    localparam int unsigned         W       = prbs_pkg::width_of(MODE)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o,
    output logic         serial_o,
    output logic         lockup_o
);

    localparam int unsigned TAP_A = prbs_pkg::tap_a_of(MODE);
    localparam int unsigned TAP_B = prbs_pkg::tap_b_of(MODE);

    logic [W-1:0] cur;
    logic [W-1:0] nxt;
    logic         stuck;

    prbs_shifter #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_shifter (
        .cur_i (cur),
        .nxt_o (nxt)
    );

    prbs_lock_detect #(.W(W)) i_lock (
        .cur_i   (cur),
        .stuck_o (stuck)
    );

    prbs_state_reg #(.W(W), .RECOVER(RECOVER)) i_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (adv_i),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .nxt_i   (nxt),
        .stuck_i (stuck),
        .state_o (cur)
    );

    // Outputs: parallel word, MSB as serial bit, lock-up flag.
    always_comb begin
        state_o  = cur;
        serial_o = cur[W-1];
        lockup_o = stuck;
    end

    AST_LOCK_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockup_o |-> serial_o); // R8

endmodule

// File: tb/test_prbs_gen.sv
`timescale 1ns/1ps
// Bench: scoreboard. The step task drives both instances and queues the words
// expected from an independent model; one monitor per instance pops and
// compares them after each edge.
module test_prbs_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_a = 1'b0, load_a = 1'b0;
    logic [6:0]  seed_a = '0;
    logic        adv_b = 1'b0, load_b = 1'b0;
    logic [30:0] seed_b = '0;
    logic [6:0]  st_a;
    logic [30:0] st_b;
    logic        ser_a, lock_a, ser_b, lock_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0]  m7  = '0;
    logic [30:0] m31 = '0;
    logic [6:0]  q7[$];
    string       t7[$];
    logic [30:0] q31[$];
    string       t31[$];

    always #2 clk = ~clk; // 250 MHz

    prbs_gen #(.MODE(prbs_pkg::PRBS7), .RECOVER(1'b0)) i_prbs_gen (
        .clk_i(clk), .rst_ni(rst_n), .adv_i(adv_a), .load_i(load_a),
        .seed_i(seed_a), .state_o(st_a), .serial_o(ser_a), .lockup_o(lock_a)
    );

    prbs_gen #(.MODE(prbs_pkg::PRBS31), .RECOVER(1'b1)) i_prbs_gen_31 (
        .clk_i(clk), .rst_ni(rst_n), .adv_i(adv_b), .load_i(load_b),
        .seed_i(seed_b), .state_o(st_b), .serial_o(ser_b), .lockup_o(lock_b)
    );

    function automatic logic [6:0] nx7(logic [6:0] s);
        return {s[5:0], ~(s[6] ^ s[5])};
    endfunction

    function automatic logic [30:0] nx31(logic [30:0] s);
        if (&s) return '0; // recovery enabled on this instance
        return {s[29:0], ~(s[30] ^ s[27])};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus to one instance and queue its expectation.
    task automatic step(input bit big, input bit adv, input bit ld,
                        input logic [30:0] sd, input string tag);
        @(negedge clk);
        if (big) begin
            adv_b = adv; load_b = ld; seed_b = sd; adv_a = 0; load_a = 0;
            if (ld) m31 = sd; else if (adv) m31 = nx31(m31);
            q31.push_back(m31); t31.push_back(tag);
        end else begin
            adv_a = adv; load_a = ld; seed_a = sd[6:0]; adv_b = 0; load_b = 0;
            if (ld) m7 = sd[6:0]; else if (adv) m7 = nx7(m7);
            q7.push_back(m7); t7.push_back(tag);
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; adv_a = 0; load_a = 0; adv_b = 0; load_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; m7 = '0; m31 = '0;
    endtask

    // Monitor: PRBS-7 instance, checks word, serial bit (R10) and flag (R8).
    always @(posedge clk) begin
        #1;
        if (q7.size() > 0) begin
            logic [6:0] e;
            string tg;
            e = q7.pop_front(); tg = t7.pop_front();
            chk({lock_a, ser_a, st_a} === {&e, e[6], e},
                {tg, "/R8/R10 (7-bit flag,msb,word)"},
                {23'd0, lock_a, ser_a, st_a}, {23'd0, &e, e[6], e});
        end
    end

    // Monitor: PRBS-31 instance.
    always @(posedge clk) begin
        #1;
        if (q31.size() > 0) begin
            logic [30:0] e;
            string tg;
            e = q31.pop_front(); tg = t31.pop_front();
            chk({lock_b, ser_b, st_b} === {&e, e[30], e},
                {tg, "/R8/R10 (31-bit)"},
                {lock_b, st_b}, {&e, e});
        end
    end

    initial begin
        logic [6:0] ref16 [16];
        logic [6:0] refs  [7];
        bit   [127:0] seen;
        int   reps;
        ref16 = '{7'h00, 7'h01, 7'h03, 7'h07, 7'h0F, 7'h1F, 7'h3F, 7'h7E,
                  7'h7D, 7'h7B, 7'h77, 7'h6F, 7'h5F, 7'h3E, 7'h7C, 7'h79};
        refs  = '{7'h7E, 7'h7D, 7'h7B, 7'h77, 7'h6F, 7'h5F, 7'h3E};

        // R1: reset state of both instances
        do_reset();
        @(posedge clk); #1;
        chk(st_a === 7'h00 && lock_a === 0, "R1", {25'd0, st_a}, 32'd0);
        chk(st_b === 31'd0 && lock_b === 0, "R1", {1'b0, st_b}, 32'd0);

        // R2: documented 16-word run from reset
        for (int i = 1; i < 16; i++) begin
            step(0, 1, 0, '0, "R2");
            chk(st_a === ref16[i], "R2", {25'd0, st_a}, {25'd0, ref16[i]});
        end

        // R3: idle cycles hold the word
        repeat (3) step(0, 0, 0, '0, "R3");
        chk(st_a === 7'h79, "R3", {25'd0, st_a}, 32'h79);

        // R4: load wins over a simultaneous advance
        step(0, 1, 1, 31'h3F, "R4");
        chk(st_a === 7'h3F, "R4", {25'd0, st_a}, 32'h3F);

        // R5: seeded run
        for (int i = 0; i < 7; i++) begin
            step(0, 1, 0, '0, "R5");
            chk(st_a === refs[i], "R5", {25'd0, st_a}, {25'd0, refs[i]});
        end

        // R6: full period with no repeated word
        do_reset();
        seen = '0; seen[0] = 1'b1; reps = 0;
        for (int i = 0; i < 127; i++) begin
            step(0, 1, 0, '0, "R6");
            if (i < 126) begin
                if (seen[st_a]) reps++;
                seen[st_a] = 1'b1;
            end
        end
        chk(reps == 0, "R6 repeats", reps, 0);
        chk(st_a === 7'h00, "R6 wrap", {25'd0, st_a}, 0);
        chk($countones(seen) == 127, "R6 distinct", $countones(seen), 127);

        // R7/R8: stuck word without recovery
        step(0, 0, 1, 31'h7F, "R7");
        chk(lock_a === 1'b1, "R8", {31'd0, lock_a}, 1);
        repeat (4) step(0, 1, 0, '0, "R7");
        chk(st_a === 7'h7F, "R7", {25'd0, st_a}, 32'h7F);
        step(0, 0, 1, 31'h7E, "R8");
        chk(lock_a === 1'b0, "R8", {31'd0, lock_a}, 0);

        // R11: 31-bit taps from reset
        do_reset();
        for (int i = 0; i < 60; i++) step(1, 1, 0, '0, "R11");
        // seeded 31-bit run from a mixed word
        step(1, 0, 1, 31'h5A5A_1234, "R11");
        for (int i = 0; i < 40; i++) step(1, 1, 0, '0, "R11");

        // R9: recovery from the stuck word
        step(1, 0, 1, {31{1'b1}}, "R9");
        chk(lock_b === 1'b1, "R8", {31'd0, lock_b}, 1);
        step(1, 1, 0, '0, "R9");
        chk(st_b === 31'd0, "R9", {1'b0, st_b}, 0);
        step(1, 1, 0, '0, "R9");
        chk(st_b === 31'd1, "R9", {1'b0, st_b}, 1);

        repeat (2) @(posedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule